// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous static RAM. The host offers one word at a time on a valid/ready request carrying an address, a write flag and write data. The controller then plays out the chip-enable, output-enable and write-enable sequence the memory expects. All three strobes are active low. It drives the address bus, and it steers a split data path: outbound data, an output-enable for that data, and inbound data. Read results come back on a one-cycle response strobe with the captured word.

Each analogue timing figure of the memory is a parameter in nanoseconds. At elaboration it is turned into a whole number of clock cycles: the figure is divided by the clock-period parameter, rounded up, and given a floor of one cycle. A single down-counter paces every state.

The state machine has seven states. IDLE is the only state in which a request is taken. A read runs IDLE to READ_ACCESS, then READ_CAPTURE, then TURNAROUND, and back to IDLE. A write runs IDLE to WRITE_SETUP, then WRITE_PULSE, then WRITE_RECOVER, and back to IDLE. Each state hands over to the next when its counter expires.

Top module: `sram_ctrl`

## Requirements
- R1: During and after a synchronous reset, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_dq_oe is 0 and req_ready is 1 (IDLE).
- R2: req_ready is 1 only in IDLE. A request is taken when req_valid and req_ready are both 1 at a rising clock edge. While the controller is busy, no strobe of a new access appears.
- R3: A read holds sram_ce_n and sram_oe_n at 0 for RA+1 consecutive cycles, with sram_we_n at 1 and sram_addr equal to the requested address. RA is the largest of ceil(T_AA/CLK), ceil(T_DOE/CLK) and ceil(T_RC/CLK)-1.
- R4: Read data is the value of sram_dq_in at the clock edge that ends the last cycle with sram_oe_n at 0. rsp_valid is 1 for exactly one cycle, the cycle after that edge, with rsp_rdata holding the captured word.
- R5: After a read, sram_ce_n and sram_oe_n are 1 and sram_dq_oe is 0 for TA = ceil(T_HZ/CLK) cycles before req_ready returns. A read occupies RA+1+TA busy cycles.
- R6: A write holds sram_ce_n at 0 with sram_we_n at 1 for one setup cycle. Then sram_we_n is 0 for WP cycles. WP is the largest of ceil(T_PWE/CLK), ceil(T_SD/CLK), ceil(T_SCE/CLK)-1 and ceil(T_AW/CLK)-1. sram_oe_n stays 1 for the whole write.
- R7: During a write, sram_dq_oe is 1 from the setup cycle through the recovery cycles. While sram_we_n is 0, sram_dq_out equals the requested data, and sram_dq_out and sram_addr hold steady.
- R8: A write occupies 1+WP+REC busy cycles, where REC = max(1, ceil(T_WC/CLK)-1-WP). The write ends on the rise of sram_we_n.
- R9: Every cycle count above is the nanosecond parameter divided by CLK_NS, rounded up, with a minimum of 1.
- R10: sram_dq_oe is never 1 while sram_oe_n is 0.
- R11: sram_we_n is never 0 unless sram_ce_n is 0.
- R12: A word written to an address is returned by a later read of that address, for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DW | Captured read data |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | AW | Memory address bus |
| sram_dq_out | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | 1 = controller drives the data bus |
| sram_dq_in | input | DW | Data returned by the memory |

## Verification
The bench builds the controller with AW=4, DW=8 and CLK_NS=5, and keeps the default timing figures. With those values every address of the 16-word space can be written and read back in several sweeps. The 5 ns period makes each derived count large enough that an off-by-one in any stage changes a measured cycle total. The bench's memory model returns a poison value until its own access time has elapsed, so capturing the read data one cycle early shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_ACCESS,
        ST_READ_CAPTURE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_RECOVER,
        ST_TURNAROUND
    } ctrl_state_e;

    // Convert a nanosecond figure to clock cycles: round up, floor of one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Subtract with a floor of zero.
    function automatic int unsigned sub_sat(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    // A state loaded with len lasts len cycles; done marks its last cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - CW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [DW-1:0] dq_in,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_rdata <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int CLK_NS = 5,
    parameter int T_RC   = 70,
    parameter int T_AA   = 70,
    parameter int T_DOE  = 35,
    parameter int T_HZ   = 25,
    parameter int T_WC   = 70,
    parameter int T_PWE  = 50,
    parameter int T_SCE  = 60,
    parameter int T_AW   = 60,
    parameter int T_SD   = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);
    // Derived cycle counts
    localparam int unsigned RD_ACC = max_u(max_u(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_DOE, CLK_NS)),
                                           sub_sat(ns_to_cyc(T_RC, CLK_NS), 1));
    localparam int unsigned TURN   = ns_to_cyc(T_HZ, CLK_NS);
    localparam int unsigned WR_PW  = max_u(max_u(ns_to_cyc(T_PWE, CLK_NS), ns_to_cyc(T_SD, CLK_NS)),
                                           max_u(sub_sat(ns_to_cyc(T_SCE, CLK_NS), 1),
                                                 sub_sat(ns_to_cyc(T_AW, CLK_NS), 1)));
    localparam int unsigned WR_REC = max_u(1, sub_sat(ns_to_cyc(T_WC, CLK_NS), 1 + WR_PW));
    localparam int unsigned MAXC   = max_u(max_u(RD_ACC, TURN), max_u(WR_PW, WR_REC));
    localparam int          CW     = $clog2(MAXC + 1);

    ctrl_state_e   st, st_nxt;
    logic          cnt_load;
    logic [CW-1:0] cnt_len;
    logic          cnt_done;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          cap_en;

    sram_wait_cnt #(.CW(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .len  (cnt_len),
        .done (cnt_done)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (st == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Transitions and counter loads
    always_comb begin
        st_nxt   = st;
        cnt_load = 1'b0;
        cnt_len  = CW'(1);
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_write) begin
                        st_nxt  = ST_WRITE_SETUP;
                        cnt_len = CW'(1);
                    end else begin
                        st_nxt  = ST_READ_ACCESS;
                        cnt_len = CW'(RD_ACC);
                    end
                end
            end
            ST_READ_ACCESS: begin
                if (cnt_done) begin
                    st_nxt   = ST_READ_CAPTURE;
                    cnt_load = 1'b1;
                    cnt_len  = CW'(1);
                end
            end
            ST_READ_CAPTURE: begin
                if (cnt_done) begin
                    st_nxt   = ST_TURNAROUND;
                    cnt_load = 1'b1;
                    cnt_len  = CW'(TURN);
                end
            end
            ST_TURNAROUND: begin
                if (cnt_done) begin
                    st_nxt = ST_IDLE;
                end
            end
            ST_WRITE_SETUP: begin
                if (cnt_done) begin
                    st_nxt   = ST_WRITE_PULSE;
                    cnt_load = 1'b1;
                    cnt_len  = CW'(WR_PW);
                end
            end
            ST_WRITE_PULSE: begin
                if (cnt_done) begin
                    st_nxt   = ST_WRITE_RECOVER;
                    cnt_load = 1'b1;
                    cnt_len  = CW'(WR_REC);
                end
            end
            ST_WRITE_RECOVER: begin
                if (cnt_done) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        req_ready  = 1'b0;
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (st)
            ST_IDLE: req_ready = 1'b1;
            ST_READ_ACCESS, ST_READ_CAPTURE: begin
                sram_ce_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_TURNAROUND: ;
            ST_WRITE_SETUP: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WRITE_PULSE: begin
                sram_ce_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WRITE_RECOVER: sram_dq_oe = 1'b1;
            default: ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign cap_en      = (st == ST_READ_CAPTURE) && cnt_done;

    sram_rd_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .dq_in     (sram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          sram_ce_n,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic [AW-1:0] sram_addr,
    input logic [DW-1:0] sram_dq_out,
    input logic          sram_dq_oe
);
    // R10
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> !sram_dq_oe);

    // R11
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> !sram_ce_n);

    // R3
    read_we_high_chk: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> sram_we_n);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && !sram_dq_oe));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_dq_out) && $stable(sram_addr)));

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (!sram_dq_oe && sram_ce_n));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int CLK = 5;
    localparam int NW = 1 << AW;

    // Expected counts, worked out from the requirement formulas
    function automatic int cd(input int ns);
        int c;
        c = (ns + CLK - 1) / CLK;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RA   = mx(mx(cd(70), cd(35)), cd(70) - 1);
    localparam int E_TA   = cd(25);
    localparam int E_WP   = mx(mx(cd(50), cd(30)), mx(cd(60) - 1, cd(60) - 1));
    localparam int E_REC  = mx(1, cd(70) - 1 - E_WP);
    localparam int MEM_ACC = cd(70);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [AW-1:0] sram_addr;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    // Memory model: data valid only after MEM_ACC clocked cycles of CE/OE low
    logic [DW-1:0] mem [NW];
    logic [DW-1:0] gold [NW];
    int lowcnt = 0;
    always @(posedge clk) begin
        if (!rst && !sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_dq_out;
        if (!sram_ce_n && !sram_oe_n) lowcnt <= lowcnt + 1;
        else lowcnt <= 0;
    end
    always_comb sram_dq_in = (!sram_ce_n && !sram_oe_n && lowcnt >= MEM_ACC) ? mem[sram_addr] : 8'hEE;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n, welo, oelo, bad_d, bad_oe;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before write", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; welo = 0; oelo = 0; bad_d = 0; bad_oe = 0;
        // R6 setup cycle: CE low, WE high
        check(!sram_ce_n && sram_we_n, "R6 setup cycle", int'({sram_ce_n, sram_we_n}), 1);
        while (!req_ready && n < 1000) begin
            if (!sram_we_n) begin
                welo++;
                if (sram_dq_out != d || sram_addr != a) bad_d++;
            end
            if (!sram_oe_n) oelo++;
            if (!sram_dq_oe) bad_oe++;
            @(negedge clk);
            n++;
        end
        check(welo == E_WP, "R6 WE low cycles", welo, E_WP);
        check(oelo == 0, "R6 OE high in write", oelo, 0);
        check(bad_d == 0, "R7 write data/addr", bad_d, 0);
        check(bad_oe == 0, "R7 data driven through write", bad_oe, 0);
        check(n == 1 + E_WP + E_REC, "R8 R9 write length", n, 1 + E_WP + E_REC);
        gold[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int n, oelo, vpos, vcnt, bad_a, bad_we, bad_z;
        logic [DW-1:0] got;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before read", int'(req_ready), 1);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; oelo = 0; vpos = -1; vcnt = 0; bad_a = 0; bad_we = 0; bad_z = 0; got = '0;
        while (!req_ready && n < 1000) begin
            if (!sram_oe_n) begin
                oelo++;
                if (sram_ce_n || sram_addr != a) bad_a++;
                if (!sram_we_n) bad_we++;
            end else if (!sram_ce_n || sram_dq_oe) begin
                bad_z++;
            end
            if (rsp_valid) begin vpos = n; got = rsp_rdata; vcnt++; end
            @(negedge clk);
            n++;
        end
        check(oelo == E_RA + 1, "R3 R9 OE low cycles", oelo, E_RA + 1);
        check(bad_a == 0 && bad_we == 0, "R3 addr/WE during read", bad_a + bad_we, 0);
        check(vpos == E_RA + 1 && vcnt == 1, "R4 rsp_valid position", vpos, E_RA + 1);
        check(got == gold[a], "R4 R12 read data", int'(got), int'(gold[a]));
        check(bad_z == 0, "R5 bus released in turnaround", bad_z, 0);
        check(n == E_RA + 1 + E_TA, "R5 read length", n, E_RA + 1 + E_TA);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin mem[i] = '0; gold[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes high in reset",
              int'({sram_ce_n, sram_oe_n, sram_we_n}), 7);
        check(!sram_dq_oe, "R1 bus off in reset", int'(sram_dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && sram_ce_n && !rsp_valid, "R1 idle after reset", int'(req_ready), 1);
        // R12 sweep: fill, read back, rewrite interleaved, read back
        for (int a = 0; a < NW; a++) do_write(AW'(a), DW'(a * 37 + 5));
        for (int a = 0; a < NW; a++) do_read(AW'(a));
        for (int a = NW - 1; a >= 0; a--) begin
            do_write(AW'(a), DW'((a * 91) ^ 8'hA5));
            do_read(AW'(a));
            do_read(AW'((a + 1) % NW));
        end
        do_write(AW'(3), 8'h00);
        do_write(AW'(3), 8'hFF);
        do_read(AW'(3));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule